// File: doc/BRIEF.md
# Dual Multiply Add/Subtract Unit

This block multiplies two operand pairs side by side and merges the two products into one result. Each pair consists of an `A_W`-bit multiplicand and a `B_W`-bit multiplier. Each product is `A_W+B_W` bits wide. The two products are either added or subtracted, and the result is one bit wider than a product, so no value is lost. A signed-mode input selects between two's-complement and unsigned interpretation of all operands. An add/subtract input selects the combining operation. Both mode inputs travel down the pipeline next to the data they apply to.

Three register stages can each be kept or removed at elaboration time:

- an input stage that holds the operands;
- a product stage that follows each multiplier;
- a result stage.

The latency is therefore anywhere from zero to three cycles. One clock enable freezes every stage, and one synchronous reset clears every stage. To build longer structures, the first pair's operands can be taken from a pair of cascade inputs instead of the normal operand ports. The second pair's operands leave the input stage on cascade outputs, so a neighbouring unit can pick them up.

Top module: `dual_muladd`

## Requirements
- R1: With `sub_mode`=0, `result` equals A0·B0 + A1·B1 taken modulo 2^(A_W+B_W+1); with unsigned operands of all ones (255 each at 8 bits) it is 0x1FC02.
- R2: With `sub_mode`=1, `result` equals A0·B0 − A1·B1 in A_W+B_W+1 bits.
- R3: With `signed_mode`=1, operands are two's complement and `result` is sign-correct; at 8 bits (−128)·(−128)+(−128)·(−128) gives 0x08000 and 127·(−128)+0 gives 0x1C080.
- R4: With `signed_mode`=0 and `sub_mode`=1, a negative difference is returned as its two's complement in A_W+B_W+1 bits with the top bit set; at 8 bits 0·0 − 255·255 gives 0x101FF.
- R5: The latency from operands to `result` is IN_REG+PIPE_REG+OUT_REG cycles, 3 by default.
- R6: The mode inputs are sampled together with their operands, so changing them every cycle gives each result the modes that came with its own operands.
- R7: While `ce`=0 and `rst`=0, no register stage changes, so `result`, `chain_a_out` and `chain_b_out` hold their values.
- R8: `rst`=1 clears every stage at the next clock edge even when `ce`=0; `result`, `chain_a_out` and `chain_b_out` are then 0.
- R9: With `chain_sel`=1, the first pair uses `chain_a_in`/`chain_b_in` in place of `a0`/`b0`.
- R10: `chain_a_out`/`chain_b_out` carry `a1`/`b1` as held by the input stage, one cycle after a `ce` edge when IN_REG=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all stages |
| ce | input | 1 | Clock enable for all stages |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| sub_mode | input | 1 | 1: subtract second product, 0: add |
| chain_sel | input | 1 | 1: first pair taken from cascade inputs |
| a0 | input | A_W | Multiplicand of pair 0 |
| b0 | input | B_W | Multiplier of pair 0 |
| a1 | input | A_W | Multiplicand of pair 1 |
| b1 | input | B_W | Multiplier of pair 1 |
| chain_a_in | input | A_W | Cascade multiplicand input |
| chain_b_in | input | B_W | Cascade multiplier input |
| chain_a_out | output | A_W | Cascade multiplicand output (pair 1 after input stage) |
| chain_b_out | output | B_W | Cascade multiplier output (pair 1 after input stage) |
| result | output | A_W+B_W+1 | Combined sum or difference |

## Verification
Two events can land in the same cycle. The first is a mode change at the inputs. The second is an older operand set, with the opposite mode, still moving through the product and result stages. The bench provokes this by flipping `signed_mode` and `sub_mode` on every cycle while new operands enter. A behavioural queue model then judges every output, and a misaligned mode shows up as a wrong sign or a wrong operation. A reset is also asserted together with `ce`=0 to show that the clear takes effect over the stall.

// File: rtl/dmas_pkg.sv
`timescale 1ns/1ps
package dmas_pkg;
  typedef struct packed {
    logic sg;   // two's-complement operands
    logic sb;   // subtract second product
  } mode_t;
endpackage

// File: rtl/dmas_stage.sv
`timescale 1ns/1ps
module dmas_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ce) q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dmas_mult.sv
`timescale 1ns/1ps
module dmas_mult #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter bit PIPE_REG = 1'b1,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           sg,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] p
);
  logic [P_W-1:0] ea, eb, prod;

  // extension to product width makes the low P_W bits exact in both modes
  always_comb begin
    ea   = {{B_W{sg & a[A_W-1]}}, a};
    eb   = {{A_W{sg & b[B_W-1]}}, b};
    prod = ea * eb;
  end

  dmas_stage #(.W(P_W), .EN(PIPE_REG)) u_pipe (
    .clk(clk), .rst(rst), .ce(ce), .d(prod), .q(p)
  );
endmodule

// File: rtl/dmas_combine.sv
`timescale 1ns/1ps
module dmas_combine #(
  parameter int P_W = 16,
  parameter bit OUT_REG = 1'b1,
  localparam int R_W = P_W + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  dmas_pkg::mode_t mode,
  input  logic [P_W-1:0] p0,
  input  logic [P_W-1:0] p1,
  output logic [R_W-1:0] r
);
  logic [R_W-1:0] e0, e1, mix;

  always_comb begin
    e0  = {mode.sg & p0[P_W-1], p0};
    e1  = {mode.sg & p1[P_W-1], p1};
    mix = mode.sb ? (e0 - e1) : (e0 + e1);
  end

  dmas_stage #(.W(R_W), .EN(OUT_REG)) u_out (
    .clk(clk), .rst(rst), .ce(ce), .d(mix), .q(r)
  );
endmodule

// File: rtl/dual_muladd.sv
`timescale 1ns/1ps
module dual_muladd #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit IN_REG   = 1'b1,
  parameter bit PIPE_REG = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  localparam int P_W     = A_W + B_W,
  localparam int R_W     = P_W + 1,
  localparam int LATENCY = int'(IN_REG) + int'(PIPE_REG) + int'(OUT_REG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           signed_mode,
  input  logic           sub_mode,
  input  logic           chain_sel,
  input  logic [A_W-1:0] a0,
  input  logic [B_W-1:0] b0,
  input  logic [A_W-1:0] a1,
  input  logic [B_W-1:0] b1,
  input  logic [A_W-1:0] chain_a_in,
  input  logic [B_W-1:0] chain_b_in,
  output logic [A_W-1:0] chain_a_out,
  output logic [B_W-1:0] chain_b_out,
  output logic [R_W-1:0] result
);
  import dmas_pkg::*;

  logic [A_W-1:0] a_src [2];
  logic [B_W-1:0] b_src [2];
  logic [A_W-1:0] a_q   [2];
  logic [B_W-1:0] b_q   [2];
  logic [P_W-1:0] prod  [2];
  mode_t mode_in, mode_s1, mode_s2;

  always_comb begin
    a_src[0] = chain_sel ? chain_a_in : a0;
    b_src[0] = chain_sel ? chain_b_in : b0;
    a_src[1] = a1;
    b_src[1] = b1;
    mode_in  = '{sg: signed_mode, sb: sub_mode};
  end

  // modes follow the same stages as the operands
  dmas_stage #(.W($bits(mode_t)), .EN(IN_REG)) u_mode_in (
    .clk(clk), .rst(rst), .ce(ce), .d(mode_in), .q(mode_s1)
  );
  dmas_stage #(.W($bits(mode_t)), .EN(PIPE_REG)) u_mode_pipe (
    .clk(clk), .rst(rst), .ce(ce), .d(mode_s1), .q(mode_s2)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    dmas_stage #(.W(A_W + B_W), .EN(IN_REG)) u_in (
      .clk(clk), .rst(rst), .ce(ce),
      .d({a_src[l], b_src[l]}), .q({a_q[l], b_q[l]})
    );
    dmas_mult #(.A_W(A_W), .B_W(B_W), .PIPE_REG(PIPE_REG)) u_mult (
      .clk(clk), .rst(rst), .ce(ce), .sg(mode_s1.sg),
      .a(a_q[l]), .b(b_q[l]), .p(prod[l])
    );
  end

  dmas_combine #(.P_W(P_W), .OUT_REG(OUT_REG)) u_comb (
    .clk(clk), .rst(rst), .ce(ce), .mode(mode_s2),
    .p0(prod[0]), .p1(prod[1]), .r(result)
  );

  assign chain_a_out = a_q[1];
  assign chain_b_out = b_q[1];
endmodule

// File: rtl/dmas_checker.sv
`timescale 1ns/1ps
module dmas_checker #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit IN_REG   = 1'b1,
  parameter bit PIPE_REG = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  localparam int R_W     = A_W + B_W + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           ce,
  input logic [A_W-1:0] a1,
  input logic [B_W-1:0] b1,
  input logic [A_W-1:0] chain_a_out,
  input logic [B_W-1:0] chain_b_out,
  input logic [R_W-1:0] result
);
  generate
    if (IN_REG && PIPE_REG && OUT_REG) begin : g_all_regs
      // R7: a stalled pipeline keeps its result
      p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(result));
    end
    if (OUT_REG) begin : g_out
      // R8: reset clears the result stage regardless of ce
      p_clear_r8: assert property (@(posedge clk)
        rst |=> (result == '0));
      p_known_r1: assert property (@(posedge clk) disable iff (rst)
        ce |=> !$isunknown(result));
    end
    if (IN_REG) begin : g_in
      // R10: cascade outputs follow the second pair through the input stage
      p_chain_r10: assert property (@(posedge clk) disable iff (rst)
        ce |=> (chain_a_out == $past(a1) && chain_b_out == $past(b1)));
      // R7: cascade outputs freeze while stalled
      p_chain_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(chain_a_out) && $stable(chain_b_out)));
    end
  endgenerate
endmodule

bind dual_muladd dmas_checker #(
  .A_W(A_W), .B_W(B_W), .IN_REG(IN_REG), .PIPE_REG(PIPE_REG), .OUT_REG(OUT_REG)
) chk_i (
  .clk(clk), .rst(rst), .ce(ce), .a1(a1), .b1(b1),
  .chain_a_out(chain_a_out), .chain_b_out(chain_b_out), .result(result)
);

// File: tb/dual_muladd_tb_top.sv
`timescale 1ns/1ps
module dual_muladd_tb_top;
  localparam int A_W = 8;
  localparam int B_W = 8;
  localparam int R_W = A_W + B_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1, ce = 1'b1, sg = 1'b0, sb = 1'b0, cs = 1'b0;
  logic [A_W-1:0] a0 = '0, a1 = '0, ca = '0;
  logic [B_W-1:0] b0 = '0, b1 = '0, cb = '0;
  logic [A_W-1:0] chain_a_out;
  logic [B_W-1:0] chain_b_out;
  logic [R_W-1:0] result;

  int tests = 0, fails = 0;
  logic [R_W-1:0] m_r1 = '0, m_r2 = '0, m_r3 = '0;
  logic [A_W-1:0] m_ca = '0;
  logic [B_W-1:0] m_cb = '0;

  always #5 clk = ~clk;

  dual_muladd dut_i (
    .clk(clk), .rst(rst), .ce(ce), .signed_mode(sg), .sub_mode(sb),
    .chain_sel(cs), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .chain_a_in(ca), .chain_b_in(cb),
    .chain_a_out(chain_a_out), .chain_b_out(chain_b_out), .result(result)
  );

  function automatic longint val_a(logic [A_W-1:0] v, logic s);
    longint x = longint'(v);
    if (s && v[A_W-1]) x = x - (longint'(1) <<< A_W);
    return x;
  endfunction

  function automatic longint val_b(logic [B_W-1:0] v, logic s);
    longint x = longint'(v);
    if (s && v[B_W-1]) x = x - (longint'(1) <<< B_W);
    return x;
  endfunction

  function automatic logic [R_W-1:0] ref_calc(logic [A_W-1:0] x0, logic [B_W-1:0] y0,
      logic [A_W-1:0] x1, logic [B_W-1:0] y1, logic s, logic d);
    longint p0 = val_a(x0, s) * val_b(y0, s);
    longint p1 = val_a(x1, s) * val_b(y1, s);
    logic [63:0] t = d ? 64'(p0 - p1) : 64'(p0 + p1);
    return t[R_W-1:0];
  endfunction

  task automatic check_val(string tag, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: the model advances after the edge, outputs compared at negedge
  task automatic step(string tag);
    @(posedge clk);
    if (rst) begin
      m_r1 = '0; m_r2 = '0; m_r3 = '0; m_ca = '0; m_cb = '0;
    end else if (ce) begin
      m_r3 = m_r2; m_r2 = m_r1;
      m_r1 = ref_calc(cs ? ca : a0, cs ? cb : b0, a1, b1, sg, sb);
      m_ca = a1; m_cb = b1;
    end
    @(negedge clk);
    check_val(tag, 64'(result), 64'(m_r3));
    check_val("R10", 64'({chain_a_out, chain_b_out}), 64'({m_ca, m_cb}));
  endtask

  task automatic set_ops(logic [A_W-1:0] x0, logic [B_W-1:0] y0,
      logic [A_W-1:0] x1, logic [B_W-1:0] y1, logic s, logic d);
    a0 = x0; b0 = y0; a1 = x1; b1 = y1; sg = s; sb = d;
  endtask

  task automatic run_single(string tag, logic [R_W-1:0] exp);
    for (int i = 0; i < 3; i++) step(tag);
    check_val(tag, 64'(result), 64'(exp));
  endtask

  task automatic rand_ops();
    a0 = A_W'($urandom); b0 = B_W'($urandom);
    a1 = A_W'($urandom); b1 = B_W'($urandom);
    ca = A_W'($urandom); cb = B_W'($urandom);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [R_W-1:0] held;
    @(negedge clk);
    step("R8"); step("R8");
    check_val("R8", 64'(result), 64'd0);
    rst = 1'b0;

    // R5: a single operand set appears after exactly three edges
    set_ops(8'd3, 8'd5, 8'd0, 8'd0, 1'b0, 1'b0);
    step("R5");
    set_ops(8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0);
    check_val("R5", 64'(result), 64'd0);
    step("R5"); check_val("R5", 64'(result), 64'd0);
    step("R5"); check_val("R5", 64'(result), 64'd15);
    step("R5"); check_val("R5", 64'(result), 64'd0);

    set_ops(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0); run_single("R1", 17'h1FC02);
    set_ops(8'd12, 8'd10, 8'd7, 8'd3, 1'b0, 1'b0);   run_single("R1", 17'd141);
    set_ops(8'h80, 8'h80, 8'h80, 8'h80, 1'b1, 1'b0); run_single("R3", 17'h08000);
    set_ops(8'h7F, 8'h80, 8'h00, 8'h00, 1'b1, 1'b0); run_single("R3", 17'h1C080);
    set_ops(8'h80, 8'h80, 8'h7F, 8'h7F, 1'b1, 1'b1); run_single("R2", 17'h000FF);
    set_ops(8'd9, 8'd9, 8'd4, 8'd5, 1'b0, 1'b1);     run_single("R2", 17'd61);
    set_ops(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b1); run_single("R4", 17'h101FF);
    check_val("R4", 64'(result[R_W-1]), 64'd1);

    // R6: modes flip every cycle while operands stream in
    for (int i = 0; i < 24; i++) begin
      rand_ops(); sg = i[0]; sb = i[1] ^ i[0];
      step("R6");
    end

    // R7: stall with changing inputs keeps every output
    held = result;
    ce = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rand_ops(); sg = ~sg; sb = ~sb;
      step("R7");
      check_val("R7", 64'(result), 64'(held));
    end
    ce = 1'b1;
    for (int i = 0; i < 30; i++) begin
      rand_ops(); ce = 1'($urandom); step("R7");
    end
    ce = 1'b1;

    // R9: cascade inputs replace the first pair
    cs = 1'b1;
    set_ops(8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0);
    ca = 8'd10; cb = 8'd10;
    run_single("R9", 17'd100);
    for (int i = 0; i < 16; i++) begin
      rand_ops(); sg = 1'($urandom); sb = 1'($urandom); step("R9");
    end
    cs = 1'b0;

    // R8: reset while stalled still clears
    rand_ops(); step("R8");
    rst = 1'b1; ce = 1'b0;
    step("R8");
    check_val("R8", 64'(result), 64'd0);
    check_val("R8", 64'({chain_a_out, chain_b_out}), 64'd0);
    rst = 1'b0; ce = 1'b1;

    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      rand_ops();
      sg = 1'($urandom); sb = 1'($urandom); cs = 1'($urandom);
      ce = ($urandom % 5) != 0;
      rst = ($urandom % 40) == 0;
      step("R1");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule